// File: doc/BRIEF.md
# Command Stream Header Decoder

This block turns a stream of 32-bit command words into individual register writes. Words enter through a valid/ready port. The parser reads the first word as a header. The header carries a starting method address, a subchannel number, a submission mode and a 13-bit field. In most modes that field is an argument count. In the immediate mode it is a data value.

In the burst modes the argument words that follow are consumed one by one. Each one leaves as a write of the form (method, subchannel, value) on a valid/ready output port. The method address advances according to the mode: it can step by one per argument, stay fixed, or step only once after the first argument. The immediate mode consumes no argument words. It produces a single write whose value comes from the header itself. An error pulse flags headers that cannot be executed.

The block is placed between a word fetcher and the engines that receive the method writes. It keeps a single output slot. The input stalls while that slot holds a write the consumer has not yet taken.

Top module: `cmd_hdr_decoder`

## Requirements
- R1: Header fields are decoded as follows: method address from bits [12:0], subchannel from bits [15:13], count or immediate from bits [28:16], mode from bits [31:29]. Every write carries the subchannel of the header that started it.
- R2: Modes 1 and 0 (a legacy alias) increment. With a count of N, the next N words are written to method, method+1, … method+N-1, with the address wrapping modulo 2^13.
- R3: Modes 3 and 2 (a legacy alias) hold the address. Each of the next N words is written to the header's method address.
- R4: Mode 5 (increment once) writes the first argument to the method address and every later argument to method+1.
- R5: Mode 4 (immediate) consumes no argument words. It produces exactly one write to the header's method, with value equal to bits [28:16] zero-extended to 32 bits. The next word is parsed as a header.
- R6: A header in modes 0 to 3 with a count of 0 produces no write, and the next word is parsed as a header.
- R7: A header in mode 6 or 7, or in mode 5 with a count of 0, raises `err` for exactly the one cycle after the header is accepted. It produces no write, and the next word is parsed as a header. At all other times `err` is low.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output fields stay unchanged.
- R9: A synchronous reset clears `out_valid` and `err` and returns the parser to expecting a header, even in the middle of an argument burst.
- R10: Writes leave in argument order. Each burst header produces exactly as many writes as its count, and no others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Command word present |
| in_ready | output | 1 | Block accepts the word this cycle |
| in_word | input | 32 | Command word (header or argument) |
| out_valid | output | 1 | A register write is presented |
| out_ready | input | 1 | Consumer takes the write this cycle |
| out_method | output | 13 | Method address of the write |
| out_subch | output | 3 | Subchannel of the write |
| out_value | output | 32 | Data of the write |
| err | output | 1 | One-cycle pulse for a rejected header |

## Verification
The bench targets several corner cases:
- A burst that starts at 0x1FFE must wrap to 0. A design that carried into the subchannel bits would write to the wrong address.
- An increment-once header with a count of one, and a burst with a count of zero, are both included. A design that mishandled them would either swallow the following header as an argument or emit a write that was never requested.
- Random back-pressure on the output checks that no argument word is lost or overwritten while the slot is full.
- A reset in the middle of a burst must send the next word to header parsing rather than into the stale burst.
- Legacy alias codes and rejected codes are mixed into the random stream. A decoder that treated any of them as the wrong class would push the output stream out of step.

// File: rtl/cmd_hdr_pkg.sv
package cmd_hdr_pkg;

   localparam int MODE_W = 3;

   localparam logic [MODE_W-1:0] MODE_INC_LEGACY  = 3'd0;
   localparam logic [MODE_W-1:0] MODE_INC         = 3'd1;
   localparam logic [MODE_W-1:0] MODE_HOLD_LEGACY = 3'd2;
   localparam logic [MODE_W-1:0] MODE_HOLD        = 3'd3;
   localparam logic [MODE_W-1:0] MODE_IMM         = 3'd4;
   localparam logic [MODE_W-1:0] MODE_ONCE        = 3'd5;

   // how the method address moves between arguments of one burst
   typedef enum logic [1:0] {
      STEP_INC  = 2'd0,
      STEP_HOLD = 2'd1,
      STEP_ONCE = 2'd2
   } step_e;

   // what a header asks the parser to do
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_BURST = 2'd1,
      ACT_IMM   = 2'd2,
      ACT_BAD   = 2'd3
   } act_e;

   typedef struct packed {
      act_e  kind;
      step_e step;
   } hdr_plan_t;

   function automatic hdr_plan_t classify(input logic [MODE_W-1:0] mode,
                                          input logic cnt_zero);
      hdr_plan_t p;
      p.kind = ACT_BAD;
      p.step = STEP_INC;
      case (mode)
         MODE_INC_LEGACY, MODE_INC: begin
            p.kind = cnt_zero ? ACT_NONE : ACT_BURST;
            p.step = STEP_INC;
         end
         MODE_HOLD_LEGACY, MODE_HOLD: begin
            p.kind = cnt_zero ? ACT_NONE : ACT_BURST;
            p.step = STEP_HOLD;
         end
         MODE_IMM: begin
            p.kind = ACT_IMM;
         end
         MODE_ONCE: begin
            p.kind = cnt_zero ? ACT_BAD : ACT_BURST;
            p.step = STEP_ONCE;
         end
         default: begin
            p.kind = ACT_BAD;
         end
      endcase
      return p;
   endfunction

endpackage

// File: rtl/cmd_hdr_split.sv
module cmd_hdr_split #(
   parameter int WORD_W  = 32,
   parameter int METH_W  = 13,
   parameter int SUBCH_W = 3,
   parameter int CNT_W   = 13
) (
   input  logic [WORD_W-1:0]               word,
   output logic [METH_W-1:0]               meth,
   output logic [SUBCH_W-1:0]              subch,
   output logic [CNT_W-1:0]                cnt,
   output logic [cmd_hdr_pkg::MODE_W-1:0]  mode,
   output logic                            cnt_zero
);
   localparam int SUBCH_LSB = METH_W;
   localparam int CNT_LSB   = SUBCH_LSB + SUBCH_W;
   localparam int MODE_LSB  = CNT_LSB + CNT_W;
   localparam int USED_W    = MODE_LSB + cmd_hdr_pkg::MODE_W;

   if (USED_W != WORD_W) begin : g_bad_layout
      $error("header fields do not fill the command word exactly");
   end
   if (METH_W < 2 || CNT_W < 1 || SUBCH_W < 1) begin : g_bad_width
      $error("header field widths too small");
   end

   assign meth     = word[SUBCH_LSB-1:0];
   assign subch    = word[CNT_LSB-1:SUBCH_LSB];
   assign cnt      = word[MODE_LSB-1:CNT_LSB];
   assign mode     = word[WORD_W-1:MODE_LSB];
   assign cnt_zero = (cnt == '0);

endmodule

// File: rtl/cmd_meth_seq.sv
module cmd_meth_seq
   import cmd_hdr_pkg::*;
#(
   parameter int METH_W  = 13,
   parameter int SUBCH_W = 3,
   parameter int CNT_W   = 13
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               hdr_load,
   input  logic [METH_W-1:0]  hdr_meth,
   input  logic [SUBCH_W-1:0] hdr_subch,
   input  logic [CNT_W-1:0]   hdr_cnt,
   input  step_e              hdr_step,
   input  logic               arg_take,
   output logic               busy,
   output logic [METH_W-1:0]  cur_meth,
   output logic [SUBCH_W-1:0] cur_subch
);
   localparam logic [METH_W-1:0] METH_ONE = METH_W'(1);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0]  rem_q;
   logic [METH_W-1:0] base_q;
   step_e             step_q;
   logic              last_arg;

   assign last_arg = (rem_q == CNT_ONE);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy      <= 1'b0;
         rem_q     <= '0;
         cur_meth  <= '0;
         base_q    <= '0;
         cur_subch <= '0;
         step_q    <= STEP_INC;
      end else if (hdr_load) begin
         busy      <= 1'b1;
         rem_q     <= hdr_cnt;
         cur_meth  <= hdr_meth;
         base_q    <= hdr_meth;
         cur_subch <= hdr_subch;
         step_q    <= hdr_step;
      end else if (arg_take) begin
         rem_q <= rem_q - CNT_ONE;
         if (last_arg) busy <= 1'b0;
         case (step_q)
            STEP_INC:  cur_meth <= cur_meth + METH_ONE;
            STEP_ONCE: cur_meth <= base_q + METH_ONE;
            default:   cur_meth <= cur_meth;
         endcase
      end
   end

   // R2
   inc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (arg_take && step_q == STEP_INC) |=> (cur_meth == $past(cur_meth) + METH_ONE));

   // R3
   hold_step_chk: assert property (@(posedge clk) disable iff (rst)
      (arg_take && step_q == STEP_HOLD) |=> $stable(cur_meth));

   // R4
   once_step_chk: assert property (@(posedge clk) disable iff (rst)
      (arg_take && step_q == STEP_ONCE) |=> (cur_meth == base_q + METH_ONE));

   // R10
   rem_dec_chk: assert property (@(posedge clk) disable iff (rst)
      (arg_take && !last_arg) |=> (busy && rem_q == $past(rem_q) - CNT_ONE));

   // R10
   burst_end_chk: assert property (@(posedge clk) disable iff (rst)
      (arg_take && last_arg) |=> !busy);

endmodule

// File: rtl/cmd_wr_slot.sv
module cmd_wr_slot #(
   parameter int WORD_W  = 32,
   parameter int METH_W  = 13,
   parameter int SUBCH_W = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load,
   input  logic [METH_W-1:0]  ld_meth,
   input  logic [SUBCH_W-1:0] ld_subch,
   input  logic [WORD_W-1:0]  ld_value,
   input  logic               out_ready,
   output logic               out_valid,
   output logic [METH_W-1:0]  out_method,
   output logic [SUBCH_W-1:0] out_subch,
   output logic [WORD_W-1:0]  out_value,
   output logic               free
);
   assign free = !out_valid || out_ready;

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
      end else if (load) begin
         out_valid <= 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_method <= '0;
         out_subch  <= '0;
         out_value  <= '0;
      end else if (load) begin
         out_method <= ld_meth;
         out_subch  <= ld_subch;
         out_value  <= ld_value;
      end
   end

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |=>
         (out_valid && $stable(out_method) && $stable(out_subch) && $stable(out_value)));

endmodule

// File: rtl/cmd_hdr_decoder.sv
module cmd_hdr_decoder
   import cmd_hdr_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int METH_W  = 13,
   parameter int SUBCH_W = 3,
   parameter int CNT_W   = 13
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   output logic               in_ready,
   input  logic [WORD_W-1:0]  in_word,
   output logic               out_valid,
   input  logic               out_ready,
   output logic [METH_W-1:0]  out_method,
   output logic [SUBCH_W-1:0] out_subch,
   output logic [WORD_W-1:0]  out_value,
   output logic               err
);
   logic [METH_W-1:0]  h_meth;
   logic [SUBCH_W-1:0] h_subch;
   logic [CNT_W-1:0]   h_cnt;
   logic [MODE_W-1:0]  h_mode;
   logic               h_cnt_zero;
   hdr_plan_t          plan;
   logic [WORD_W-1:0]  imm_ext;

   logic               busy;
   logic [METH_W-1:0]  cur_meth;
   logic [SUBCH_W-1:0] cur_subch;

   logic accept, hdr_take, arg_take, hdr_load, imm_emit, slot_load, slot_free;
   logic [METH_W-1:0]  ld_meth;
   logic [SUBCH_W-1:0] ld_subch;
   logic [WORD_W-1:0]  ld_value;

   cmd_hdr_split #(
      .WORD_W(WORD_W), .METH_W(METH_W), .SUBCH_W(SUBCH_W), .CNT_W(CNT_W)
   ) u_split (
      .word(in_word), .meth(h_meth), .subch(h_subch), .cnt(h_cnt),
      .mode(h_mode), .cnt_zero(h_cnt_zero)
   );

   if (WORD_W > CNT_W) begin : g_imm_pad
      assign imm_ext = {{(WORD_W-CNT_W){1'b0}}, h_cnt};
   end else begin : g_imm_fit
      assign imm_ext = h_cnt[WORD_W-1:0];
   end

   assign plan      = classify(h_mode, h_cnt_zero);
   assign in_ready  = slot_free;
   assign accept    = in_valid && in_ready;
   assign hdr_take  = accept && !busy;
   assign arg_take  = accept && busy;
   assign hdr_load  = hdr_take && (plan.kind == ACT_BURST);
   assign imm_emit  = hdr_take && (plan.kind == ACT_IMM);
   assign slot_load = imm_emit || arg_take;
   assign ld_meth   = busy ? cur_meth  : h_meth;
   assign ld_subch  = busy ? cur_subch : h_subch;
   assign ld_value  = busy ? in_word   : imm_ext;

   cmd_meth_seq #(
      .METH_W(METH_W), .SUBCH_W(SUBCH_W), .CNT_W(CNT_W)
   ) u_seq (
      .clk(clk), .rst(rst),
      .hdr_load(hdr_load), .hdr_meth(h_meth), .hdr_subch(h_subch),
      .hdr_cnt(h_cnt), .hdr_step(plan.step),
      .arg_take(arg_take),
      .busy(busy), .cur_meth(cur_meth), .cur_subch(cur_subch)
   );

   cmd_wr_slot #(
      .WORD_W(WORD_W), .METH_W(METH_W), .SUBCH_W(SUBCH_W)
   ) u_slot (
      .clk(clk), .rst(rst),
      .load(slot_load), .ld_meth(ld_meth), .ld_subch(ld_subch), .ld_value(ld_value),
      .out_ready(out_ready), .out_valid(out_valid),
      .out_method(out_method), .out_subch(out_subch), .out_value(out_value),
      .free(slot_free)
   );

   always_ff @(posedge clk) begin
      if (rst) err <= 1'b0;
      else     err <= hdr_take && (plan.kind == ACT_BAD);
   end

   // R8
   in_stall_chk: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !out_ready) |-> !in_ready);

   // R7
   err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      err |-> (!out_valid && !busy));

   // R5
   imm_write_chk: assert property (@(posedge clk) disable iff (rst)
      imm_emit |=> (out_valid && !busy && out_value == $past(imm_ext)
                    && out_method == $past(h_meth)));

   // R6
   empty_burst_chk: assert property (@(posedge clk) disable iff (rst)
      (hdr_take && plan.kind == ACT_NONE) |=> !busy);

   // R9
   reset_state_chk: assert property (@(posedge clk)
      $past(rst) |-> (!out_valid && !err && !busy));

endmodule

// File: tb/cmd_hdr_decoder_test.sv
module cmd_hdr_decoder_test;
   localparam int WD_LIMIT = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_word = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [12:0] out_method;
   logic [2:0]  out_subch;
   logic [31:0] out_value;
   logic        err;

   always #10ns clk = ~clk;

   cmd_hdr_decoder uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
      .out_valid(out_valid), .out_ready(out_ready), .out_method(out_method),
      .out_subch(out_subch), .out_value(out_value), .err(err)
   );

   typedef struct {
      logic [12:0] m;
      logic [2:0]  s;
      logic [31:0] v;
      string       tag;
   } wr_t;

   wr_t         expq[$];
   logic [31:0] words[$];
   int checks = 0, errors = 0, cyc = 0;
   bit timed_out = 0;

   // reference parser state
   int          m_rem = 0;
   int          m_kind = 0;   // 0 step, 1 hold, 2 once
   logic [12:0] m_cur, m_base;
   logic [2:0]  m_sub;
   bit          exp_err_next = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_hdr(input int mode, input int sub,
                                          input int meth, input int cnt);
      return {mode[2:0], cnt[12:0], sub[2:0], meth[12:0]};
   endfunction

   function automatic string step_tag(input int kind, input int mode);
      if (kind == 0) return (mode == 0) ? "R2-legacy" : "R2";
      if (kind == 1) return (mode == 2) ? "R3-legacy" : "R3";
      return "R4";
   endfunction

   int m_mode = 0;

   task automatic model_accept(input logic [31:0] w);
      if (m_rem == 0) begin
         int mode, cnt;
         mode = int'(w[31:29]);
         cnt  = int'(w[28:16]);
         m_sub  = w[15:13];
         m_cur  = w[12:0];
         m_base = w[12:0];
         m_mode = mode;
         case (mode)
            0, 1: begin m_kind = 0; m_rem = cnt; end
            2, 3: begin m_kind = 1; m_rem = cnt; end
            5: begin
               m_kind = 2;
               if (cnt == 0) exp_err_next = 1;
               else m_rem = cnt;
            end
            4: expq.push_back('{w[12:0], w[15:13], {19'd0, w[28:16]}, "R5"});
            default: exp_err_next = 1;
         endcase
      end else begin
         expq.push_back('{m_cur, m_sub, w, step_tag(m_kind, m_mode)});
         m_rem--;
         if (m_kind == 0) m_cur = m_cur + 13'd1;
         else if (m_kind == 2) m_cur = m_base + 13'd1;
      end
   endtask

   task automatic add_burst(input int mode, input int sub, input int meth, input int cnt);
      words.push_back(mk_hdr(mode, sub, meth, cnt));
      if (mode != 4 && mode < 6 && !(mode == 5 && cnt == 0))
         for (int i = 0; i < cnt; i++) words.push_back($urandom);
   endtask

   task automatic run_words(input int ready_pct);
      int idx = 0;
      bit acc_prev = 0, stalled = 0;
      logic [12:0] hm; logic [2:0] hs; logic [31:0] hv;
      while (!timed_out && (idx < words.size() || expq.size() != 0 || in_valid || exp_err_next)) begin
         @(negedge clk);
         cyc++;
         if (cyc > WD_LIMIT) begin
            timed_out = 1;
            check(0, "WATCHDOG", "run did not finish", cyc, WD_LIMIT);
            break;
         end
         // R7: err is a one-cycle pulse only after a rejected header
         check(err === exp_err_next, "R7", "err pulse", {31'd0, err}, {31'd0, exp_err_next});
         exp_err_next = 0;
         // R8: a stalled write is held unchanged
         if (stalled)
            check(out_valid && out_method == hm && out_subch == hs && out_value == hv,
                  "R8", "held write changed", out_value, hv);
         if (!in_valid || acc_prev) begin
            if (idx < words.size() && ($urandom % 4) != 0) begin
               in_valid = 1'b1;
               in_word  = words[idx];
            end else begin
               in_valid = 1'b0;
            end
         end
         out_ready = (($urandom % 100) < ready_pct);
         #1;
         stalled = out_valid && !out_ready;
         if (stalled) begin
            check(!in_ready, "R8", "in_ready during stall", {31'd0, in_ready}, 32'd0);
            hm = out_method; hs = out_subch; hv = out_value;
         end
         if (out_valid && out_ready) begin
            if (expq.size() == 0) begin
               check(0, "R10", "unexpected write", out_value, 32'd0);
            end else begin
               wr_t e;
               e = expq.pop_front();
               check(out_method == e.m, e.tag, "method", {19'd0, out_method}, {19'd0, e.m});
               check(out_subch == e.s, "R1", "subchannel", {29'd0, out_subch}, {29'd0, e.s});
               check(out_value == e.v, e.tag, "value", out_value, e.v);
            end
         end
         acc_prev = in_valid && in_ready;
         if (acc_prev) begin
            model_accept(in_word);
            idx++;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      words.delete();
   endtask

   initial begin
      void'($urandom(32'h5EED_0417));
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #1;
      // R9: state right after reset
      check(!out_valid && !err && in_ready, "R9", "reset state",
            {29'd0, out_valid, err, in_ready}, 32'd1);

      // directed corner cases
      add_burst(1, 3, 13'h1FFE, 3);   // R2 with address wrap
      add_burst(0, 1, 13'h0040, 2);   // R2 legacy alias
      add_burst(3, 5, 13'h0100, 3);   // R3
      add_burst(2, 7, 13'h0200, 2);   // R3 legacy alias
      add_burst(5, 2, 13'h0300, 1);   // R4 count one
      add_burst(5, 4, 13'h1FFF, 4);   // R4 with wrap of method+1
      add_burst(4, 6, 13'h0077, 13'h1ABC); // R5
      add_burst(1, 0, 13'h0010, 0);   // R6 empty burst
      add_burst(3, 0, 13'h0011, 0);   // R6 empty burst
      add_burst(4, 1, 13'h0012, 0);   // R5 immediate zero
      add_burst(6, 0, 13'h0013, 2);   // R7
      add_burst(7, 0, 13'h0014, 0);   // R7
      add_burst(5, 0, 13'h0015, 0);   // R7 once with count zero
      add_burst(1, 2, 13'h0016, 1);
      run_words(100);
      add_burst(1, 3, 13'h0500, 5);
      run_words(20);                  // heavy back-pressure, R8

      // constrained random mix
      for (int h = 0; h < 250; h++) begin
         int mode;
         mode = int'($urandom % 8);
         if (mode == 4) add_burst(mode, int'($urandom % 8), int'($urandom % 8192), int'($urandom % 8192));
         else add_burst(mode, int'($urandom % 8), int'($urandom % 8192), int'($urandom % 6));
      end
      run_words(60);

      // R9: reset in the middle of a burst
      words.push_back(mk_hdr(1, 2, 13'h0020, 4));
      words.push_back(32'hAAAA_0001);
      words.push_back(32'hAAAA_0002);
      run_words(100);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      m_rem = 0;
      exp_err_next = 0;
      #1;
      check(!out_valid && !err, "R9", "state after mid-burst reset",
            {30'd0, out_valid, err}, 32'd0);
      words.push_back(mk_hdr(4, 5, 13'h0033, 13'h0123));  // must parse as header
      run_words(100);
      check(expq.size() == 0, "R9", "writes left after reset test", expq.size(), 0);
      check(expq.size() == 0, "R10", "expected writes never emitted", expq.size(), 0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule